// File: doc/BRIEF.md
# Programmable Watchdog Timer with Output Steering

This block supervises a host processor for a real-time-clock style peripheral. Software programs an 8-bit control word that holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The block then counts down the resulting timeout on a 16 Hz time-base tick. If the processor neither rewrites the control word nor toggles the restart pin before the count runs out, the block declares a timeout.

On a timeout the block sets a sticky flag that software reads and clears. The steering bit then picks one of two actions. The first raises an interrupt that holds until software clears it. The second drives a timed active-low reset pulse, wipes the control word and tells the neighbouring logic to clear its control bits.

The block also decides what drives the shared interrupt/frequency-test pin. Interrupt sources always take priority over the test square wave.

Top module: `wdt_steer_top`

## Requirements
- R1: After reset the control word is 00h, `flag_q` reads 00h, `irq_ft_n` is high (with `ftest_en`=0 and `alarm_n`=1), `rst_out_n` is high and `cfg_clr` is low.
- R2: The control word is laid out as {bit 7 = steering, bits 6:2 = multiplier M, bits 1:0 = resolution R}. The timeout is M × 4^R ticks of `tick16`, so R=00/01/10/11 means 1/16, 1/4, 1 or 4 s per multiplier step. The flag is 0 after the (M×4^R − 1)th tick following a write and 1 after the next tick.
- R3: Every transition of `wd_pin`, rising or falling, restarts the full timeout from the stored control word. The pin passes through a 2-flop synchronizer, so the restart takes effect on the third clock edge after the change.
- R4: A write to the control word restarts the countdown using the newly written value.
- R5: `flag_q` bit 7 is the watchdog flag and bits 6:0 read 0. A `flag_rd` strobe clears the flag on the next edge. If a timeout and a read fall in the same cycle, the timeout wins.
- R6: With steering = 0, a timeout drives `irq_ft_n` low. It stays low through writes of nonzero values and is released only by a write of 00h, which also disables the watchdog.
- R7: With steering = 1, a timeout drives `rst_out_n` low for exactly RST_CYCLES clocks from the edge after the timeout tick. On that same edge it clears the control word and pulses `cfg_clr` high for one clock. `irq_ft_n` is not driven low.
- R8: `irq_ft_n` is low whenever the watchdog interrupt is active or `alarm_n` is low. Otherwise it follows `ftest_wave` when `ftest_en`=1 and is high when `ftest_en`=0.
- R9: With a multiplier of 0 no countdown runs and no timeout ever occurs, whatever the number of ticks.
- R10: While `pwr_dn` is high, the control word is cleared, any countdown is cancelled, the interrupt is released and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-clock 16 Hz time-base enable |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word write data |
| flag_rd | input | 1 | Flag register read strobe (clears flag) |
| flag_q | output | 8 | Flag register read data, bit 7 = watchdog flag |
| wd_pin | input | 1 | Asynchronous restart pin, both edges restart |
| pwr_dn | input | 1 | Power-down indication, clears and disables |
| alarm_n | input | 1 | Active-low alarm interrupt request sharing the pin |
| ftest_en | input | 1 | Frequency-test output enable |
| ftest_wave | input | 1 | Frequency-test square wave |
| irq_ft_n | output | 1 | Shared active-low interrupt / frequency-test pin |
| rst_out_n | output | 1 | Active-low processor reset pulse |
| cfg_clr | output | 1 | One-clock pulse telling neighbours to clear their control bits |

## Verification
The countdown is tried with every resolution code and with small, mid-range and full-scale multipliers. Checking the flag one tick before and exactly at the expected count separates the four shift amounts and catches an off-by-one load. Restarts are driven by rising and falling pin edges and by a rewrite to a shorter value, each landing partway through a count, so a missing restart shows up as an early timeout. Steering is tried both ways, and the reset pulse is measured at its last low clock and first high clock. Pin arbitration is exercised with an alarm request, with the test wave at both levels, and with a pending interrupt overriding the wave.

// File: rtl/wdt_pkg.sv
// Shared widths and helpers for the watchdog block.
// Assumes the time base is 16 Hz, so the finest resolution step is one tick.
package wdt_pkg;
    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    localparam int WORD_W = 1 + MULT_W + RES_W;
    localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

    typedef logic [MULT_W-1:0] mult_t;
    typedef logic [RES_W-1:0]  res_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Timeout in 16 Hz ticks: multiplier times four to the power of the resolution code.
    function automatic cnt_t load_ticks(input mult_t m, input res_t r);
        cnt_t v;
        v = cnt_t'(m);
        return v << {r, 1'b0};
    endfunction
endpackage

// File: rtl/wdt_pin_edge.sv
// Synchronizes the asynchronous restart pin and flags either edge.
// Assumes the pin is held low during reset; the pulse comes out 2 edges after capture.
module wdt_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_p
);
    logic s1, s2, s3;

    // Two-flop synchronizer followed by a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign edge_p = s2 ^ s3;
endmodule

// File: rtl/wdt_down_cnt.sv
// Loadable tick-driven down counter that reports the tick that reaches zero.
// Assumes load and clear are single-clock strobes; clear has priority over load.
module wdt_down_cnt
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic load,
    input  cnt_t load_val,
    input  logic tick,
    output cnt_t cnt,
    output logic expire
);
    // Hold, reload or decrement the remaining tick count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - cnt_t'(1);
    end

    assign expire = tick && (cnt == cnt_t'(1)) && !load && !clear;
endmodule

// File: rtl/wdt_rst_pulse.sv
// Produces an active-low pulse of a fixed number of clocks after a start strobe.
// Assumes RST_CYCLES >= 1; a start during a pulse restarts the full length.
module wdt_rst_pulse #(
    parameter int RST_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse_n
);
    localparam int PW = $clog2(RST_CYCLES + 1);
    logic [PW-1:0] left;

    // Count the remaining low clocks of the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left <= '0;
        else if (start)
            left <= PW'(RST_CYCLES);
        else if (left != '0)
            left <= left - PW'(1);
    end

    assign pulse_n = (left == '0);
endmodule

// File: rtl/wdt_steer_top.sv
// Watchdog top: control word, sticky flag, steering and shared-pin arbitration.
// Assumes tick16 is a one-clock enable at 16 Hz and all strobes are synchronous.
module wdt_steer_top
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              flag_rd,
    output logic [7:0]        flag_q,
    input  logic              wd_pin,
    input  logic              pwr_dn,
    input  logic              alarm_n,
    input  logic              ftest_en,
    input  logic              ftest_wave,
    output logic              irq_ft_n,
    output logic              rst_out_n,
    output logic              cfg_clr
);
    localparam int STEER_B = WORD_W - 1;

    logic [WORD_W-1:0] wd_reg;
    logic              flag;
    logic              irq_q;
    logic              pin_edge;
    logic              load;
    cnt_t              load_val;
    cnt_t              cnt;
    logic              expire;
    logic              rst_start;

    wdt_pin_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (wd_pin),
        .edge_p (pin_edge)
    );

    assign load     = wr_en || pin_edge;
    assign load_val = wr_en ? load_ticks(wr_data[RES_W +: MULT_W], wr_data[RES_W-1:0])
                            : load_ticks(wd_reg[RES_W +: MULT_W], wd_reg[RES_W-1:0]);

    wdt_down_cnt u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (pwr_dn),
        .load     (load),
        .load_val (load_val),
        .tick     (tick16),
        .cnt      (cnt),
        .expire   (expire)
    );

    assign rst_start = expire && wd_reg[STEER_B];

    wdt_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rst_start),
        .pulse_n (rst_out_n)
    );

    // Control word: written by software, wiped by power-down or a reset-steered timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wd_reg <= '0;
        else if (pwr_dn)
            wd_reg <= '0;
        else if (wr_en)
            wd_reg <= wr_data;
        else if (rst_start)
            wd_reg <= '0;
    end

    // Sticky flag: set on timeout, cleared by a flag read; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (expire)
            flag <= 1'b1;
        else if (flag_rd)
            flag <= 1'b0;
    end

    // Interrupt latch: set by an interrupt-steered timeout, released by a zero write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (pwr_dn)
            irq_q <= 1'b0;
        else if (expire && !wd_reg[STEER_B])
            irq_q <= 1'b1;
        else if (wr_en && wr_data == '0)
            irq_q <= 1'b0;
    end

    // One-clock request to neighbours to clear their control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_clr <= 1'b0;
        else
            cfg_clr <= rst_start;
    end

    assign flag_q = {flag, 7'b0};

    // Shared pin: interrupts first, then the test wave, else idle high.
    always_comb begin
        if (irq_q || !alarm_n)
            irq_ft_n = 1'b0;
        else if (ftest_en)
            irq_ft_n = ftest_wave;
        else
            irq_ft_n = 1'b1;
    end
endmodule

// File: rtl/wdt_steer_chk.sv
// Property checker for wdt_steer_top, attached with bind.
// Assumes it sees the top's internal counter, control word and strobes.
module wdt_steer_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              expire,
    input logic              load,
    input logic              pwr_dn,
    input logic              flag_rd,
    input logic              alarm_n,
    input cnt_t              cnt,
    input logic [WORD_W-1:0] wd_reg,
    input logic [7:0]        flag_q,
    input logic              irq_ft_n,
    input logic              rst_out_n,
    input logic              cfg_clr
);
    // R2
    count_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !pwr_dn) |=> (cnt <= $past(cnt)));

    // R5
    flag_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !expire) |=> (flag_q == 8'h00));

    // R5
    flag_set_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (flag_q == 8'h80));

    // R6
    irq_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !wd_reg[WORD_W-1] && !pwr_dn) |=> !irq_ft_n);

    // R7
    rst_pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && wd_reg[WORD_W-1]) |=> (!rst_out_n && cfg_clr && wd_reg == '0));

    // R8
    alarm_wins_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_n |-> !irq_ft_n);

    // R9
    zero_mult_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_reg[WORD_W-2:RES_W] == '0) |-> !expire);

    // R10
    pwr_dn_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (wd_reg == '0 && cnt == '0));
endmodule

bind wdt_steer_top wdt_steer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .load      (load),
    .pwr_dn    (pwr_dn),
    .flag_rd   (flag_rd),
    .alarm_n   (alarm_n),
    .cnt       (cnt),
    .wd_reg    (wd_reg),
    .flag_q    (flag_q),
    .irq_ft_n  (irq_ft_n),
    .rst_out_n (rst_out_n),
    .cfg_clr   (cfg_clr)
);

// File: tb/wdt_steer_top_tb_top.sv
// Self-checking bench: a vector table for timeout lengths, then directed cases.
module wdt_steer_top_tb_top;
    localparam int RST_CYC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       flag_rd = 1'b0;
    logic [7:0] flag_q;
    logic       wd_pin = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       alarm_n = 1'b1;
    logic       ftest_en = 1'b0;
    logic       ftest_wave = 1'b0;
    logic       irq_ft_n;
    logic       rst_out_n;
    logic       cfg_clr;

    int total = 0;
    int bad = 0;

    // {control word, expected ticks}
    localparam logic [23:0] VECS [0:5] = '{
        {8'h0C, 16'd3},
        {8'h09, 16'd8},
        {8'h0E, 16'd48},
        {8'h07, 16'd64},
        {8'h7C, 16'd31},
        {8'h17, 16'd320}
    };

    always #2.5 clk = ~clk;

    wdt_steer_top #(.RST_CYCLES(RST_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .flag_rd(flag_rd), .flag_q(flag_q), .wd_pin(wd_pin), .pwr_dn(pwr_dn),
        .alarm_n(alarm_n), .ftest_en(ftest_en), .ftest_wave(ftest_wave),
        .irq_ft_n(irq_ft_n), .rst_out_n(rst_out_n), .cfg_clr(cfg_clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick16 = 1'b1;
            @(negedge clk); tick16 = 1'b0;
        end
    endtask

    task automatic read_flag();
        @(negedge clk); flag_rd = 1'b1;
        @(negedge clk); flag_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flag", flag_q, 8'h00);
        chk("R1 irq", irq_ft_n, 1);
        chk("R1 rst", rst_out_n, 1);
        chk("R1 cfg_clr", cfg_clr, 0);

        // R2 timeout length for each vector, R5 read clear, R6 release by zero write
        for (int k = 0; k < 6; k++) begin
            do_write(VECS[k][23:16]);
            ticks(int'(VECS[k][15:0]) - 1);
            chk("R2 early flag", flag_q, 8'h00);
            chk("R2 early irq", irq_ft_n, 1);
            ticks(1);
            chk("R2 flag at count", flag_q, 8'h80);
            chk("R6 irq asserted", irq_ft_n, 0);
            read_flag();
            chk("R5 read clears", flag_q, 8'h00);
            do_write(8'h00);
            chk("R6 zero write releases", irq_ft_n, 1);
        end

        // R3 rising then falling pin edge restarts a 4-tick count
        do_write(8'h10);
        ticks(3);
        @(negedge clk); wd_pin = 1'b1;
        repeat (4) @(negedge clk);
        ticks(3);
        chk("R3 rising edge restart", flag_q, 8'h00);
        @(negedge clk); wd_pin = 1'b0;
        repeat (4) @(negedge clk);
        ticks(3);
        chk("R3 falling edge restart", flag_q, 8'h00);
        ticks(1);
        chk("R3 expiry after restart", flag_q, 8'h80);

        // R6 nonzero write keeps interrupt
        do_write(8'h10);
        chk("R6 nonzero write keeps irq", irq_ft_n, 0);
        // R8 pending interrupt beats the test wave
        ftest_en = 1'b1; ftest_wave = 1'b1;
        @(negedge clk);
        chk("R8 irq over wave", irq_ft_n, 0);
        do_write(8'h00);
        read_flag();
        chk("R8 wave high", irq_ft_n, 1);
        ftest_wave = 1'b0;
        @(negedge clk);
        chk("R8 wave low", irq_ft_n, 0);
        ftest_wave = 1'b1; alarm_n = 1'b0;
        @(negedge clk);
        chk("R8 alarm wins", irq_ft_n, 0);
        alarm_n = 1'b1; ftest_en = 1'b0; ftest_wave = 1'b0;
        @(negedge clk);
        chk("R8 idle high", irq_ft_n, 1);

        // R4 rewrite to a shorter value restarts with the new count
        do_write(8'h10);
        ticks(3);
        do_write(8'h08);
        ticks(1);
        chk("R4 not yet", flag_q, 8'h00);
        ticks(1);
        chk("R4 new value expires", flag_q, 8'h80);
        do_write(8'h00);
        read_flag();

        // R5 timeout and read in the same cycle: flag stays set
        do_write(8'h08);
        ticks(1);
        @(negedge clk); tick16 = 1'b1; flag_rd = 1'b1;
        @(negedge clk); tick16 = 1'b0; flag_rd = 1'b0;
        chk("R5 set wins over read", flag_q, 8'h80);
        do_write(8'h00);
        read_flag();

        // R7 reset-steered timeout
        do_write(8'h88);
        ticks(1);
        @(negedge clk); tick16 = 1'b1;
        @(negedge clk); tick16 = 1'b0;
        chk("R7 rst low", rst_out_n, 0);
        chk("R7 cfg_clr pulse", cfg_clr, 1);
        chk("R7 no irq", irq_ft_n, 1);
        chk("R7 flag set", flag_q, 8'h80);
        @(negedge clk);
        chk("R7 cfg_clr one clock", cfg_clr, 0);
        repeat (RST_CYC - 2) @(negedge clk);
        chk("R7 last low clock", rst_out_n, 0);
        @(negedge clk);
        chk("R7 pulse ended", rst_out_n, 1);
        read_flag();
        ticks(10);
        chk("R7 word cleared", flag_q, 8'h00);

        // R9 zero multiplier never times out
        do_write(8'h03);
        ticks(200);
        chk("R9 disabled", flag_q, 8'h00);

        // R10 power-down cancels a running count and ignores writes
        do_write(8'h10);
        ticks(2);
        @(negedge clk); pwr_dn = 1'b1; wr_en = 1'b1; wr_data = 8'h08;
        @(negedge clk); pwr_dn = 1'b0; wr_en = 1'b0;
        ticks(10);
        chk("R10 count cancelled", flag_q, 8'h00);
        // R10 power-down releases a pending interrupt
        do_write(8'h08);
        ticks(2);
        chk("R10 irq before", irq_ft_n, 0);
        @(negedge clk); pwr_dn = 1'b1;
        @(negedge clk); pwr_dn = 1'b0;
        chk("R10 irq released", irq_ft_n, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule